// File: doc/BRIEF.md
# MSI Ring Logger

This block takes message-signalled interrupt writes, each a 32-bit data word offered on a valid/ready port, and records every one as a 16-byte entry in a circular buffer held in system memory. Each entry goes out through a simple memory write master. The block keeps a producer offset (where the next entry lands) and takes a consumer offset from software. While the two differ it holds an interrupt line high toward the host.

Software programs the 64-bit buffer base, chooses a power-of-two ring size from 32 KB to 256 KB, and sets enables through a small register port. It consumes entries by writing the consumer offset. When the ring is full, the block either stalls the message port or discards the message and records a sticky overflow flag. Which of the two it does depends on a control bit.

Top module: `msi_ring_logger`

## Requirements
- R1: A register read (reg_req high, reg_we low) returns data on reg_rdata with reg_rvalid high exactly one cycle after the request. The register addresses are: 0 control, 3 base high word, 4 base low word, 5 consumer offset, 6 producer offset. Any other address reads zero.
- R2: The control register has these fields: bit 0 enable, bit 1 full detection, bit 3 interrupt enable, bit 4 stall-on-full, and bits 9:8 size code. Bit 16 reads the full status and is read-only. Bit 17 is the sticky overflow flag, cleared by writing 1 to it.
- R3: A message accepted while enabled, and not refused as full, produces exactly one memory write. Its address is {base high, base low} plus the producer offset. Its 128-bit data holds the message word in bits 31:0, with byte 0 in bits 7:0, and zeros in bits 127:32.
- R4: mem_req, mem_addr and mem_data stay stable until mem_accept. On the accept cycle the producer offset advances by 16, modulo the ring size. No message is accepted while a write is pending.
- R5: The ring size is 2^(15+code) bytes. Offsets wrap at that size and read back with bits 3:0 and all bits at or above 15+code as zero. A written consumer offset is masked the same way. Writes to the producer offset register are ignored.
- R6: irq is high exactly when enable, interrupt enable and (consumer offset != producer offset) all hold.
- R7: The ring is full when (producer + 16) mod size equals the consumer offset. Control bit 16 reads 1 only when the ring is full and full detection is set.
- R8: When the ring is full and both full detection and stall-on-full are set, msi_ready is low.
- R9: When the ring is full, full detection is set and stall-on-full is clear, a message is accepted and discarded. No write is issued, the producer offset is unchanged, and the overflow flag is set.
- R10: With enable clear, messages are accepted and discarded, no memory write starts, and irq is low.
- R11: After reset all registers read zero, irq and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| msi_valid | input | 1 | Message offered |
| msi_data | input | 32 | Message data word |
| msi_ready | output | 1 | Message taken when high with msi_valid |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory write byte address |
| mem_data | output | 128 | Memory write entry |
| mem_accept | input | 1 | Memory write accepted |
| irq | output | 1 | Interrupt to host |

## Verification
A wrong producer offset shows up on mem_addr on the very next logged message, and on irq as soon as the offsets are compared. A wrong full decision shows on msi_ready, or as a missing or extra write, in the cycle the next message is offered. The bench mirrors the ring in a behavioural model and compares ready, request, address, data and irq every cycle. It also runs the producer offset through a full wrap of the smallest ring, so a wrong modulo shows as a misplaced address within one entry of the wrap point.

// File: rtl/msi_log_pkg.sv
package msi_log_pkg;
  localparam int unsigned DW          = 32;
  localparam int unsigned MEM_AW      = 2 * DW;
  localparam int unsigned ENTRY_SHIFT = 4;
  localparam int unsigned ENTRY_W     = 8 << ENTRY_SHIFT;
  localparam int unsigned REG_AW      = 3;
  localparam int unsigned MIN_SHIFT   = 15;
  localparam int unsigned SIZE_CODE_W = 2;
  localparam int unsigned SIZE_CODES  = 1 << SIZE_CODE_W;
  localparam int unsigned OFS_W       = MIN_SHIFT + SIZE_CODES - 1;

  localparam logic [OFS_W-1:0] ENTRY_INC  = OFS_W'(1 << ENTRY_SHIFT);
  localparam logic [OFS_W-1:0] ALIGN_MASK = ~OFS_W'((1 << ENTRY_SHIFT) - 1);

  // control register bit positions
  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_FULLDET = 1;
  localparam int unsigned CB_IRQEN   = 3;
  localparam int unsigned CB_STOP    = 4;
  localparam int unsigned CB_SIZE    = 8;
  localparam int unsigned CB_FULL_ST = 16;
  localparam int unsigned CB_OVF     = 17;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL    = 3'd0,
    RA_BASE_HI = 3'd3,
    RA_BASE_LO = 3'd4,
    RA_CONS    = 3'd5,
    RA_PROD    = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic                   en;
    logic                   full_det;
    logic                   irq_en;
    logic                   stop;
    logic [SIZE_CODE_W-1:0] size;
  } ctrl_t;

  function automatic logic [OFS_W-1:0] ofs_mask(input logic [SIZE_CODE_W-1:0] code);
    logic [OFS_W-1:0] ones;
    ones = '1;
    return (ones >> (SIZE_CODES - 1 - int'(code))) & ALIGN_MASK;
  endfunction
endpackage

// File: rtl/msi_log_regs.sv
module msi_log_regs
  import msi_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [OFS_W-1:0]  prod_m,
  input  logic              ring_full,
  input  logic              ovf_set,
  output logic              reg_rvalid,
  output logic [DW-1:0]     reg_rdata,
  output ctrl_t             ctrl,
  output logic [MEM_AW-1:0] base,
  output logic [OFS_W-1:0]  cons_m,
  output logic [OFS_W-1:0]  mask
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [DW-1:0]    hi_q, hi_d, lo_q, lo_d;
  logic [OFS_W-1:0] cons_q, cons_d;
  logic             ovf_q, ovf_d;
  logic             rvalid_q;
  logic [DW-1:0]    rdata_q, rdata_d, rd_word;
  logic             wr_hit, rd_hit;

  assign wr_hit = reg_req & reg_we;
  assign rd_hit = reg_req & ~reg_we;
  assign mask   = ofs_mask(ctrl_q.size);
  assign cons_m = cons_q & mask;
  assign ctrl   = ctrl_q;
  assign base   = {hi_q, lo_q};

  always_comb begin
    rd_word = '0;
    case (reg_addr)
      RA_CTRL: begin
        rd_word[CB_EN]                     = ctrl_q.en;
        rd_word[CB_FULLDET]                = ctrl_q.full_det;
        rd_word[CB_IRQEN]                  = ctrl_q.irq_en;
        rd_word[CB_STOP]                   = ctrl_q.stop;
        rd_word[CB_SIZE +: SIZE_CODE_W]    = ctrl_q.size;
        rd_word[CB_FULL_ST]                = ring_full & ctrl_q.full_det;
        rd_word[CB_OVF]                    = ovf_q;
      end
      RA_BASE_HI: rd_word = hi_q;
      RA_BASE_LO: rd_word = lo_q;
      RA_CONS:    rd_word[OFS_W-1:0] = cons_m;
      RA_PROD:    rd_word[OFS_W-1:0] = prod_m;
      default:    rd_word = '0;
    endcase
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    hi_d    = hi_q;
    lo_d    = lo_q;
    cons_d  = cons_q;
    ovf_d   = ovf_q;
    rdata_d = rd_hit ? rd_word : rdata_q;
    if (wr_hit) begin
      case (reg_addr)
        RA_CTRL: begin
          ctrl_d.en       = reg_wdata[CB_EN];
          ctrl_d.full_det = reg_wdata[CB_FULLDET];
          ctrl_d.irq_en   = reg_wdata[CB_IRQEN];
          ctrl_d.stop     = reg_wdata[CB_STOP];
          ctrl_d.size     = reg_wdata[CB_SIZE +: SIZE_CODE_W];
          if (reg_wdata[CB_OVF]) ovf_d = 1'b0;
        end
        RA_BASE_HI: hi_d   = reg_wdata;
        RA_BASE_LO: lo_d   = reg_wdata;
        RA_CONS:    cons_d = reg_wdata[OFS_W-1:0] & ALIGN_MASK;
        default:    ;
      endcase
    end
    if (ovf_set) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      cons_q   <= '0;
      ovf_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      cons_q   <= cons_d;
      ovf_q    <= ovf_d;
      rvalid_q <= rd_hit;
      rdata_q  <= rdata_d;
    end
  end

  assign reg_rvalid = rvalid_q;
  assign reg_rdata  = rdata_q;
endmodule

// File: rtl/msi_log_ring.sv
module msi_log_ring
  import msi_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl,
  input  logic [MEM_AW-1:0]  base,
  input  logic [OFS_W-1:0]   cons_m,
  input  logic [OFS_W-1:0]   mask,
  input  logic               msi_valid,
  input  logic [DW-1:0]      msi_data,
  output logic               msi_ready,
  output logic               mem_req,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_data,
  input  logic               mem_accept,
  output logic [OFS_W-1:0]   prod_m,
  output logic               ring_full,
  output logic               ovf_set,
  output logic               irq
);
  logic              busy_q, busy_d;
  logic [OFS_W-1:0]  prod_q, prod_d, prod_nxt;
  logic [MEM_AW-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic              full_act, stall, drop, take, log_en, done;

  assign prod_m    = prod_q & mask;
  assign prod_nxt  = (prod_q + ENTRY_INC) & mask;
  assign ring_full = (prod_nxt == cons_m);
  assign full_act  = ctrl.en & ctrl.full_det & ring_full;
  assign stall     = full_act & ctrl.stop;
  assign drop      = full_act & ~ctrl.stop;
  assign msi_ready = ~busy_q & ~stall;
  assign take      = msi_valid & msi_ready;
  assign log_en    = take & ctrl.en & ~drop;
  assign ovf_set   = take & drop;
  assign done      = busy_q & mem_accept;

  always_comb begin
    busy_d = busy_q;
    prod_d = prod_q;
    if (done) begin
      busy_d = 1'b0;
      prod_d = prod_nxt;
    end else if (log_en) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prod_q <= '0;
    end else begin
      busy_q <= busy_d;
      prod_q <= prod_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (log_en) begin
      addr_q <= base + {{(MEM_AW-OFS_W){1'b0}}, prod_m};
      data_q <= msi_data;
    end
  end

  assign mem_req  = busy_q;
  assign mem_addr = addr_q;
  assign mem_data = {{(ENTRY_W-DW){1'b0}}, data_q};
  assign irq      = ctrl.en & ctrl.irq_en & (prod_m != cons_m);
endmodule

// File: rtl/msi_ring_logger.sv
module msi_ring_logger
  import msi_log_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_req,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic               reg_rvalid,
  output logic [DW-1:0]      reg_rdata,
  input  logic               msi_valid,
  input  logic [DW-1:0]      msi_data,
  output logic               msi_ready,
  output logic               mem_req,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_data,
  input  logic               mem_accept,
  output logic               irq
);
  ctrl_t             ctrl;
  logic [MEM_AW-1:0] base;
  logic [OFS_W-1:0]  cons_m, prod_m, mask;
  logic              ring_full, ovf_set;

  msi_log_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .prod_m(prod_m), .ring_full(ring_full), .ovf_set(ovf_set),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .base(base), .cons_m(cons_m), .mask(mask)
  );

  msi_log_ring u_ring (
    .clk(clk), .rst_n(rst_n),
    .ctrl(ctrl), .base(base), .cons_m(cons_m), .mask(mask),
    .msi_valid(msi_valid), .msi_data(msi_data), .msi_ready(msi_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_accept(mem_accept),
    .prod_m(prod_m), .ring_full(ring_full), .ovf_set(ovf_set), .irq(irq)
  );
endmodule

// File: rtl/msi_log_chk.sv
module msi_log_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_req,
  input logic         reg_we,
  input logic         reg_rvalid,
  input logic         msi_ready,
  input logic         mem_req,
  input logic         mem_accept,
  input logic [63:0]  mem_addr,
  input logic [127:0] mem_data,
  input logic         irq,
  input logic         ctrl_en,
  input logic         ctrl_irq_en,
  input logic         ctrl_fd,
  input logic         ctrl_stop,
  input logic         ring_full
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_we |=> reg_rvalid);  // R1
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_accept |=> !mem_req);  // R3
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_data[127:32] == 96'd0);  // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_accept |=> mem_req && $stable(mem_addr) && $stable(mem_data));  // R4
  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !msi_ready);  // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_en && ctrl_irq_en) |-> !irq);  // R6
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en && ctrl_fd && ctrl_stop && ring_full |-> !msi_ready);  // R8
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en && !mem_req |=> !mem_req);  // R10
endmodule

bind msi_ring_logger msi_log_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we), .reg_rvalid(reg_rvalid),
  .msi_ready(msi_ready), .mem_req(mem_req), .mem_accept(mem_accept),
  .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
  .ctrl_en(ctrl.en), .ctrl_irq_en(ctrl.irq_en), .ctrl_fd(ctrl.full_det),
  .ctrl_stop(ctrl.stop), .ring_full(ring_full)
);

// File: tb/sim_msi_ring_logger.sv
`timescale 1ns/1ps
module sim_msi_ring_logger;
  logic clk, rst_n;
  logic reg_req, reg_we, reg_rvalid, msi_valid, msi_ready, mem_req, mem_accept, irq;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, msi_data;
  logic [63:0] mem_addr;
  logic [127:0] mem_data;
  int checks, errors, acc_delay, wcnt;

  msi_ring_logger u0 (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_ctrl, m_hi, m_lo, m_data;
  logic [63:0] m_addr;
  int m_cons, m_prod, mk;
  bit m_busy, m_ovf, m_full, m_ovs, m_en, m_fd, m_st;

  function automatic int size_mask(input logic [31:0] c);
    return ((1 << (15 + int'(c[9:8]))) - 1) & ~15;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_hi = 0; m_lo = 0; m_data = 0; m_addr = 0;
      m_cons = 0; m_prod = 0; m_busy = 0; m_ovf = 0;
    end else begin
      mk = size_mask(m_ctrl);
      m_en = m_ctrl[0]; m_fd = m_ctrl[1]; m_st = m_ctrl[4];
      m_full = (((m_prod + 16) & mk) == (m_cons & mk));
      m_ovs = 0;
      if (m_busy) begin
        if (mem_accept) begin m_busy = 0; m_prod = (m_prod + 16) & mk; end
      end else if (msi_valid && !(m_en && m_fd && m_full && m_st)) begin
        if (m_en && !(m_fd && m_full)) begin
          m_busy = 1;
          m_addr = {m_hi, m_lo} + 64'(m_prod & mk);
          m_data = msi_data;
        end else if (m_en) m_ovs = 1;
      end
      if (reg_req && reg_we) begin
        case (reg_addr)
          3'd0: begin m_ctrl = reg_wdata & 32'h31B; if (reg_wdata[17]) m_ovf = 0; end
          3'd3: m_hi = reg_wdata;
          3'd4: m_lo = reg_wdata;
          3'd5: m_cons = int'(reg_wdata & 32'h3FFF0);
          default: ;
        endcase
      end
      if (m_ovs) m_ovf = 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic int k = size_mask(m_ctrl);
      automatic bit f = (((m_prod + 16) & k) == (m_cons & k));
      automatic bit er = !m_busy && !(m_ctrl[0] && m_ctrl[1] && f && m_ctrl[4]);
      automatic bit ei = m_ctrl[0] && m_ctrl[3] && ((m_prod & k) != (m_cons & k));
      chk(msi_ready == er, "R8 msi_ready", 128'(msi_ready), 128'(er));
      chk(mem_req == m_busy, "R3 mem_req", 128'(mem_req), 128'(m_busy));
      if (mem_req && m_busy) begin
        chk(mem_addr == m_addr, "R3 mem_addr", 128'(mem_addr), 128'(m_addr));
        chk(mem_data == 128'(m_data), "R3 mem_data", mem_data, 128'(m_data));
      end
      chk(irq == ei, "R6 irq", 128'(irq), 128'(ei));
    end
  end

  // memory acceptor with programmable latency
  initial begin
    mem_accept = 0; wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_accept) begin
        if (wcnt >= acc_delay) begin mem_accept = 1; wcnt = 0; end
        else wcnt++;
      end else mem_accept = 0;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_req = 0;
    chk(reg_rvalid == 1'b1, {tag, " rvalid"}, 128'(reg_rvalid), 128'(1));
    chk(reg_rdata == exp, tag, 128'(reg_rdata), 128'(exp));
  endtask

  task automatic send_msi(input logic [31:0] d);
    @(negedge clk); msi_valid = 1; msi_data = d;
    while (!msi_ready) @(negedge clk);
    @(negedge clk); msi_valid = 0;
  endtask

  task automatic wait_idle();
    while (mem_req) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    checks = 0; errors = 0; acc_delay = 0;
    rst_n = 0; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    msi_valid = 0; msi_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk(irq == 0 && mem_req == 0, "R11 irq/mem_req", 128'({irq, mem_req}), 128'(0));
    reg_check(3'd0, 32'h0, "R11 ctrl");
    reg_check(3'd6, 32'h0, "R11 producer");
    reg_check(3'd2, 32'h0, "R1 unmapped");
    // R10 disabled: message swallowed
    send_msi(32'hDEAD0001);
    repeat (3) @(negedge clk);
    // R3 logging
    reg_write(3'd3, 32'h1);
    reg_write(3'd4, 32'h8000_0000);
    reg_write(3'd0, 32'h9);
    reg_check(3'd3, 32'h1, "R1 base hi");
    reg_check(3'd4, 32'h8000_0000, "R1 base lo");
    acc_delay = 0; send_msi(32'hA1B2C3D4); wait_idle();
    acc_delay = 2; send_msi(32'h00000055); wait_idle();
    acc_delay = 5; send_msi(32'hFFFFFFFF); wait_idle();
    reg_check(3'd6, 32'h30, "R4 producer advance");
    reg_check(3'd0, 32'h9, "R2 ctrl readback");
    @(negedge clk); chk(irq == 1, "R6 irq pending", 128'(irq), 128'(1));
    // R6/R5 consumer offset
    reg_write(3'd5, 32'h30);
    @(negedge clk); chk(irq == 0, "R6 irq cleared", 128'(irq), 128'(0));
    reg_write(3'd5, 32'h12345677);
    reg_check(3'd5, 32'h5670, "R5 consumer mask");
    reg_write(3'd6, 32'hABC);
    reg_check(3'd6, 32'h30, "R5 producer write ignored");
    // R7/R8 stall on full
    reg_write(3'd5, 32'h40);
    reg_write(3'd0, 32'h1B);
    reg_check(3'd0, 32'h1001B, "R7 full status");
    acc_delay = 1;
    @(negedge clk); msi_valid = 1; msi_data = 32'h0BADF00D;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk(msi_ready == 0, "R8 stalled", 128'(msi_ready), 128'(0));
    end
    reg_write(3'd5, 32'h50);
    while (!msi_ready) @(negedge clk);
    @(negedge clk); msi_valid = 0;
    wait_idle();
    reg_check(3'd6, 32'h40, "R8 released write");
    // R9 drop on full
    reg_write(3'd0, 32'h0B);
    reg_check(3'd0, 32'h1000B, "R7 full status drop mode");
    send_msi(32'h11112222);
    repeat (2) @(negedge clk);
    reg_check(3'd0, 32'h3000B, "R9 overflow sticky");
    reg_check(3'd6, 32'h40, "R9 producer unchanged");
    reg_write(3'd0, 32'h2000B);
    reg_check(3'd0, 32'h1000B, "R2 overflow clear");
    // R5 wrap of smallest ring, full detection off
    reg_write(3'd5, 32'h40);
    reg_write(3'd0, 32'h09);
    acc_delay = 0;
    for (int i = 0; i < 2050; i++) begin
      send_msi(32'(i)); wait_idle();
    end
    reg_check(3'd6, 32'h60, "R5 producer wrap");
    reg_write(3'd0, 32'h309);
    reg_check(3'd0, 32'h309, "R2 size code");
    reg_check(3'd6, 32'h60, "R5 producer large ring");
    send_msi(32'h77); wait_idle();
    reg_check(3'd6, 32'h70, "R4 advance large ring");
    reg_write(3'd5, 32'h3FFFF);
    reg_check(3'd5, 32'h3FFF0, "R5 consumer mask large ring");
    // R10 disable
    reg_write(3'd0, 32'h0);
    @(negedge clk); chk(irq == 0, "R10 irq off", 128'(irq), 128'(0));
    send_msi(32'h99);
    repeat (3) @(negedge clk);
    chk(mem_req == 0, "R10 no write", 128'(mem_req), 128'(0));
    reg_check(3'd6, 32'h70, "R10 producer held");
    summary();
  end
endmodule